// File: doc/BRIEF.md
# PCI Relocatable Address Resolver

This block turns a three-cell PCI physical address (a flags cell, a middle cell and a low cell) into a bus space and an absolute 32-bit address. The flags cell carries the relocation, prefetch and alias flags, the space code, and the bus, device, function and register-number fields. When accepted, a request's fields are validated in a single cycle. Non-relocatable and configuration requests resolve at once. Relocatable I/O and memory requests search a small table of assigned base-register entries, one entry per clock, for the entry with the same register number, and add that entry's base to the offset.

Software or a boot sequencer fills the table through a plain write port while the block is idle. The caller presents a request when `req_ready` is high. The outcome arrives as a one-cycle pulse on either `res_done` or `res_err`, together with the space, the address and a result code.

Top module: `pci_addr_resolver`

## Requirements
- R1: After reset `req_ready` is 1 and both `res_done` and `res_err` are 0.
- R2: Flags-cell fields: bit 31 non-relocatable (n), bit 30 prefetch (p), bit 29 alias/low-memory (t), bits 25:24 space code, bits 7:0 register number. Space code 0 reports space 0 (config), code 1 reports space 1 (I/O), and codes 2 and 3 both report space 2 (memory). A config request returns the low cell as the address.
- R3: A non-zero middle cell, or a relocatable request with space code 3, ends with error code 1.
- R4: A request with n set completes with the low cell as the address, one clock after acceptance, without using the table.
- R5: A relocatable I/O or 32-bit-memory request scans the table from entry 0 upward. The first entry whose register field equals the request's register field gives the address: the request's low cell plus that entry's low cell. The result is code 0.
- R6: If the scan reaches an entry with n clear or register field zero before a match, it ends with error code 5.
- R7: A matching entry whose space code differs from the request's ends with error code 6.
- R8: If no entry in the table matches, the scan ends with error code 7.
- R9: Register numbers must be legal, or the request ends with error code 2. With n set, the register must be 0. Relocatable I/O accepts 0x10 to 0x24 in steps of 4. Relocatable 32-bit memory accepts the same values plus 0x30. Config requests are not checked.
- R10: p set with any space code other than 2 gives error code 3. t set with space code 2 and a low cell of 0x100000 or above gives error code 4.
- R11: When several checks fail, the reported code is the first in the order 1, 3, 2, 4. Every error reports address 0, and the space reflects the request's space code.
- R12: Each result is a single-cycle pulse, and `res_done` and `res_err` are never high together. `req_ready` is low from acceptance until the pulse has ended. A request presented while `req_ready` is low is ignored.
- R13: The result for a direct request pulses in the cycle right after acceptance. A scan that stops at entry k pulses k+1 cycles after that, so a full miss over 8 entries takes 8 cycles more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_hi | input | 32 | Flags/field cell of the request |
| req_mid | input | 32 | Middle cell (must be zero) |
| req_lo | input | 32 | Low cell (address or offset) |
| req_ready | output | 1 | Block idle, request will be taken |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Table entry index |
| tbl_hi | input | 32 | Entry flags cell |
| tbl_lo | input | 32 | Entry base address |
| res_done | output | 1 | Success pulse |
| res_err | output | 1 | Error pulse |
| res_code | output | 3 | Result code (0 ok, 1..7 errors) |
| res_space | output | 2 | Resolved space: 0 config, 1 I/O, 2 memory |
| res_addr | output | 32 | Absolute address (0 on error) |

## Verification
The assertions check on every cycle that results are single, exclusive pulses and that `req_ready` drops after acceptance. They also check that a non-zero middle cell always yields code 1, that a clean non-relocatable request returns its low cell in the next cycle, and that an unusable table entry under the scan always ends in code 5. Only the bench scenarios can show several things: the first-match order of the scan, the sum of base and offset, the exact scan latency for each entry position, the priority among competing field errors, and that requests presented while busy are dropped.

// File: rtl/pci_res_pkg.sv
package pci_res_pkg;

   localparam int HI_N_BIT   = 31;
   localparam int HI_P_BIT   = 30;
   localparam int HI_T_BIT   = 29;
   localparam int HI_SS_MSB  = 25;
   localparam int HI_SS_LSB  = 24;
   localparam int HI_REG_MSB = 7;

   typedef enum logic [1:0] {
      SP_CFG = 2'd0,
      SP_IO  = 2'd1,
      SP_MEM = 2'd2
   } space_e;

   typedef enum logic [2:0] {
      RC_OK        = 3'd0,
      RC_WIDE      = 3'd1,
      RC_BAD_REG   = 3'd2,
      RC_BAD_PREF  = 3'd3,
      RC_RANGE     = 3'd4,
      RC_BAD_TABLE = 3'd5,
      RC_TYPE      = 3'd6,
      RC_NO_BASE   = 3'd7
   } rcode_e;

   localparam logic [1:0] SS_CFG   = 2'd0;
   localparam logic [1:0] SS_IO    = 2'd1;
   localparam logic [1:0] SS_MEM32 = 2'd2;
   localparam logic [1:0] SS_MEM64 = 2'd3;

endpackage

// File: rtl/pra_field_check.sv
module pra_field_check
   import pci_res_pkg::*;
#(
   parameter int          CELL_W        = 32,
   parameter logic [31:0] LOW_MEM_LIMIT = 32'h0010_0000
) (
   input  logic [CELL_W-1:0] hi,
   input  logic [CELL_W-1:0] mid,
   input  logic [CELL_W-1:0] lo,
   output space_e            space,
   output rcode_e            code,
   output logic              need_scan
);

   logic       fl_n, fl_p, fl_t;
   logic [1:0] ss;
   logic [7:0] regn;
   logic       io_set_ok, reg_ok;

   assign fl_n = hi[HI_N_BIT];
   assign fl_p = hi[HI_P_BIT];
   assign fl_t = hi[HI_T_BIT];
   assign ss   = hi[HI_SS_MSB:HI_SS_LSB];
   assign regn = hi[HI_REG_MSB:0];

   // base-register numbers 0x10..0x24 on a 4-byte stride
   assign io_set_ok = (regn >= 8'h10) && (regn <= 8'h24) && (regn[1:0] == 2'b00);

   always_comb begin
      if (fl_n) begin
         reg_ok = (regn == 8'h00);
      end else begin
         unique case (ss)
            SS_IO:    reg_ok = io_set_ok;
            SS_MEM32: reg_ok = io_set_ok || (regn == 8'h30);
            SS_MEM64: reg_ok = (regn == 8'h10) || (regn == 8'h18) || (regn == 8'h20);
            default:  reg_ok = 1'b1;
         endcase
      end
   end

   always_comb begin
      unique case (ss)
         SS_CFG:  space = SP_CFG;
         SS_IO:   space = SP_IO;
         default: space = SP_MEM;
      endcase
   end

   always_comb begin
      if ((mid != '0) || (!fl_n && ss == SS_MEM64))
         code = RC_WIDE;
      else if (fl_p && ss != SS_MEM32)
         code = RC_BAD_PREF;
      else if (ss != SS_CFG && !reg_ok)
         code = RC_BAD_REG;
      else if (fl_t && ss == SS_MEM32 && lo >= LOW_MEM_LIMIT)
         code = RC_RANGE;
      else
         code = RC_OK;
   end

   assign need_scan = !fl_n && (ss == SS_IO || ss == SS_MEM32);

endmodule

// File: rtl/pra_base_table.sv
module pra_base_table #(
   parameter int CELL_W = 32,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [CELL_W-1:0] whi,
   input  logic [CELL_W-1:0] wlo,
   input  logic [IDX_W-1:0]  ridx,
   output logic [CELL_W-1:0] rhi,
   output logic [CELL_W-1:0] rlo
);

   logic [CELL_W-1:0] ent_hi [DEPTH];
   logic [CELL_W-1:0] ent_lo [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [CELL_W-1:0] h_q, l_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            h_q <= '0;
            l_q <= '0;
         end else if (we && widx == IDX_W'(gi)) begin
            h_q <= whi;
            l_q <= wlo;
         end
      end
      assign ent_hi[gi] = h_q;
      assign ent_lo[gi] = l_q;
   end

   assign rhi = ent_hi[ridx];
   assign rlo = ent_lo[ridx];

endmodule

// File: rtl/pci_addr_resolver.sv
module pci_addr_resolver
   import pci_res_pkg::*;
#(
   parameter int          CELL_W        = 32,
   parameter int          DEPTH         = 8,
   parameter logic [31:0] LOW_MEM_LIMIT = 32'h0010_0000,
   localparam int         IDX_W         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CELL_W-1:0] req_hi,
   input  logic [CELL_W-1:0] req_mid,
   input  logic [CELL_W-1:0] req_lo,
   output logic              req_ready,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [CELL_W-1:0] tbl_hi,
   input  logic [CELL_W-1:0] tbl_lo,
   output logic              res_done,
   output logic              res_err,
   output logic [2:0]        res_code,
   output logic [1:0]        res_space,
   output logic [CELL_W-1:0] res_addr
);

   if (CELL_W != 32) begin : g_bad_cell
      $error("pci_addr_resolver: CELL_W must be 32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("pci_addr_resolver: DEPTH must be at least 2");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} state_e;

   state_e            state;
   logic [IDX_W-1:0]  scan_idx;
   logic [CELL_W-1:0] q_hi, q_lo;
   logic [CELL_W-1:0] e_hi, e_lo;
   space_e            chk_space;
   rcode_e            chk_code;
   logic              chk_scan;
   logic              accept, e_valid, e_hit, e_last;

   pra_field_check #(.CELL_W(CELL_W), .LOW_MEM_LIMIT(LOW_MEM_LIMIT)) u_chk (
      .hi(req_hi), .mid(req_mid), .lo(req_lo),
      .space(chk_space), .code(chk_code), .need_scan(chk_scan)
   );

   pra_base_table #(.CELL_W(CELL_W), .DEPTH(DEPTH)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we), .widx(tbl_idx), .whi(tbl_hi), .wlo(tbl_lo),
      .ridx(scan_idx), .rhi(e_hi), .rlo(e_lo)
   );

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign e_valid   = e_hi[HI_N_BIT] && (e_hi[HI_REG_MSB:0] != 8'h00);
   assign e_hit     = (e_hi[HI_REG_MSB:0] == q_hi[HI_REG_MSB:0]);
   assign e_last    = (scan_idx == IDX_W'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         scan_idx  <= '0;
         q_hi      <= '0;
         q_lo      <= '0;
         res_done  <= 1'b0;
         res_err   <= 1'b0;
         res_code  <= RC_OK;
         res_space <= SP_CFG;
         res_addr  <= '0;
      end else begin
         res_done <= 1'b0;
         res_err  <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               q_hi      <= req_hi;
               q_lo      <= req_lo;
               res_space <= chk_space;
               scan_idx  <= '0;
               if (chk_code != RC_OK) begin
                  res_err  <= 1'b1;
                  res_code <= chk_code;
                  res_addr <= '0;
                  state    <= ST_FIN;
               end else if (chk_scan) begin
                  state <= ST_SCAN;
               end else begin
                  res_done <= 1'b1;
                  res_code <= RC_OK;
                  res_addr <= req_lo;
                  state    <= ST_FIN;
               end
            end
            ST_SCAN: begin
               if (!e_valid) begin
                  res_err  <= 1'b1;
                  res_code <= RC_BAD_TABLE;
                  res_addr <= '0;
                  state    <= ST_FIN;
               end else if (e_hit) begin
                  if (e_hi[HI_SS_MSB:HI_SS_LSB] != q_hi[HI_SS_MSB:HI_SS_LSB]) begin
                     res_err  <= 1'b1;
                     res_code <= RC_TYPE;
                     res_addr <= '0;
                  end else begin
                     res_done <= 1'b1;
                     res_code <= RC_OK;
                     res_addr <= q_lo + e_lo;
                  end
                  state <= ST_FIN;
               end else if (e_last) begin
                  res_err  <= 1'b1;
                  res_code <= RC_NO_BASE;
                  res_addr <= '0;
                  state    <= ST_FIN;
               end else begin
                  scan_idx <= scan_idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);
   // R12
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |=> !res_err);
   // R12
   excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_done, res_err}));
   // R12
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   // R3
   wide_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_mid != '0) |=> (res_err && res_code == RC_WIDE));
   // R4
   nonreloc_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_hi[HI_N_BIT] && chk_code == RC_OK)
         |=> (res_done && res_addr == $past(req_lo)));
   // R6
   bad_entry_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCAN && !e_valid) |=> (res_err && res_code == RC_BAD_TABLE));

endmodule

// File: tb/tb_pci_addr_resolver.sv
`timescale 1ns/1ps
module tb_pci_addr_resolver;

   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_hi = '0, req_mid = '0, req_lo = '0;
   logic        req_ready;
   logic        tbl_we = 1'b0;
   logic [2:0]  tbl_idx = '0;
   logic [31:0] tbl_hi = '0, tbl_lo = '0;
   logic        res_done, res_err;
   logic [2:0]  res_code;
   logic [1:0]  res_space;
   logic [31:0] res_addr;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   bit ended    = 0;

   typedef struct {
      logic [2:0]  code;
      logic [1:0]  space;
      logic [31:0] addr;
      int          lat;
      int          acc;
      string       tag;
   } item_t;

   item_t sb_q[$];

   pci_addr_resolver #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_hi(req_hi), .req_mid(req_mid), .req_lo(req_lo),
      .req_ready(req_ready),
      .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_hi(tbl_hi), .tbl_lo(tbl_lo),
      .res_done(res_done), .res_err(res_err), .res_code(res_code),
      .res_space(res_space), .res_addr(res_addr)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mk_hi(bit n, bit p, bit t, logic [1:0] ss, logic [7:0] rg);
      return {n, p, t, 3'b000, ss, 8'h00, 5'h00, 3'h0, rg};
   endfunction

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic tbl_write(int idx, logic [31:0] hi, logic [31:0] lo);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = idx[2:0]; tbl_hi = hi; tbl_lo = lo;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic send(logic [31:0] hi, logic [31:0] mid, logic [31:0] lo,
                       logic [2:0] ecode, logic [1:0] espace, logic [31:0] eaddr,
                       int elat, string tag);
      item_t it;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_hi = hi; req_mid = mid; req_lo = lo;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      it.code = ecode; it.space = espace; it.addr = eaddr;
      it.lat = elat; it.acc = cyc; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compare every result pulse with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && !ended && (res_done || res_err)) begin
         logic [2:0] got;
         got = res_done ? 3'd0 : res_code;
         if (sb_q.size() == 0) begin
            check(1'b0, "R12", "unexpected result", {29'd0, got}, 32'd0);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(got == it.code, it.tag, "code", {29'd0, got}, {29'd0, it.code});
            check(res_space == it.space, it.tag, "space", {30'd0, res_space}, {30'd0, it.space});
            check(res_addr == it.addr, it.tag, "addr", res_addr, it.addr);
            check((cyc - it.acc) == it.lat, {it.tag, " R13"}, "latency",
                  32'(cyc - it.acc), 32'(it.lat));
            check(!(res_done && res_err), "R12", "done and err together", 32'(res_err), 32'd0);
         end
      end
   end

   task automatic summary();
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'd1);
      check(res_done == 1'b0 && res_err == 1'b0, "R1", "pulses in reset",
            {30'd0, res_done, res_err}, 32'd0);
      rst_n = 1'b1;

      // base table: n set, reg non-zero
      tbl_write(0, mk_hi(1, 0, 0, 2'd1, 8'h10), 32'h0000_1000);
      tbl_write(1, mk_hi(1, 0, 0, 2'd2, 8'h14), 32'h2000_0000);
      tbl_write(2, mk_hi(1, 0, 0, 2'd2, 8'h30), 32'h0004_0000);
      tbl_write(3, mk_hi(1, 0, 0, 2'd1, 8'h18), 32'h0000_0300);

      // R2 config space direct
      send(32'h0000_0800, 0, 32'h44, 3'd0, 2'd0, 32'h44, 0, "R2");
      // R4 non-relocatable I/O
      send(mk_hi(1, 0, 0, 2'd1, 8'h00), 0, 32'h1234, 3'd0, 2'd1, 32'h1234, 0, "R4");
      // R2 64-bit code, non-relocatable, maps to memory
      send(mk_hi(1, 0, 0, 2'd3, 8'h00), 0, 32'hABCD, 3'd0, 2'd2, 32'hABCD, 0, "R2");
      // R3 non-zero middle cell
      send(mk_hi(1, 0, 0, 2'd1, 8'h00), 32'h1, 32'h10, 3'd1, 2'd1, 32'h0, 0, "R3");
      // R3 relocatable 64-bit
      send(mk_hi(0, 0, 0, 2'd3, 8'h10), 0, 32'h10, 3'd1, 2'd2, 32'h0, 0, "R3");
      // R5 hit at entry 0
      send(mk_hi(0, 0, 0, 2'd1, 8'h10), 0, 32'h8, 3'd0, 2'd1, 32'h1008, 1, "R5");
      // R5 hit at entry 2
      send(mk_hi(0, 0, 0, 2'd2, 8'h30), 0, 32'h100, 3'd0, 2'd2, 32'h0004_0100, 3, "R5");
      // R7 type conflict at entry 1
      send(mk_hi(0, 0, 0, 2'd1, 8'h14), 0, 32'h4, 3'd6, 2'd1, 32'h0, 2, "R7");
      // R6 empty entry 4 reached
      send(mk_hi(0, 0, 0, 2'd2, 8'h24), 0, 32'h4, 3'd5, 2'd2, 32'h0, 5, "R6");
      // R9 register legality
      send(mk_hi(0, 0, 0, 2'd1, 8'h30), 0, 32'h0, 3'd2, 2'd1, 32'h0, 0, "R9");
      send(mk_hi(0, 0, 0, 2'd1, 8'h12), 0, 32'h0, 3'd2, 2'd1, 32'h0, 0, "R9");
      send(mk_hi(1, 0, 0, 2'd2, 8'h04), 0, 32'h0, 3'd2, 2'd2, 32'h0, 0, "R9");
      // R10 prefetch and low-memory rules
      send(mk_hi(1, 1, 0, 2'd1, 8'h00), 0, 32'h0, 3'd3, 2'd1, 32'h0, 0, "R10");
      send(mk_hi(1, 1, 0, 2'd2, 8'h00), 0, 32'h5, 3'd0, 2'd2, 32'h5, 0, "R10");
      send(mk_hi(1, 0, 1, 2'd2, 8'h00), 0, 32'h0010_0000, 3'd4, 2'd2, 32'h0, 0, "R10");
      send(mk_hi(1, 0, 1, 2'd2, 8'h00), 0, 32'h000F_FFFF, 3'd0, 2'd2, 32'h000F_FFFF, 0, "R10");
      // R11 priority among failing checks
      send(mk_hi(1, 1, 0, 2'd1, 8'h00), 32'h7, 32'h0, 3'd1, 2'd1, 32'h0, 0, "R11");
      send(mk_hi(0, 1, 0, 2'd1, 8'h13), 0, 32'h0, 3'd3, 2'd1, 32'h0, 0, "R11");
      send(mk_hi(1, 0, 1, 2'd2, 8'h08), 0, 32'h0020_0000, 3'd2, 2'd2, 32'h0, 0, "R11");

      // complete the table
      tbl_write(4, mk_hi(1, 0, 0, 2'd2, 8'h1C), 32'h0000_0010);
      tbl_write(5, mk_hi(1, 0, 0, 2'd2, 8'h1C), 32'h0000_0020);
      tbl_write(6, mk_hi(1, 0, 0, 2'd2, 8'h14), 32'h0000_0030);
      tbl_write(7, mk_hi(1, 0, 0, 2'd1, 8'h24), 32'h0000_0500);

      // R5 first match wins (entry 4 before entry 5)
      send(mk_hi(0, 0, 0, 2'd2, 8'h1C), 0, 32'h2, 3'd0, 2'd2, 32'h12, 5, "R5");
      // R13 match at the last entry
      send(mk_hi(0, 0, 0, 2'd1, 8'h24), 0, 32'h1, 3'd0, 2'd1, 32'h501, 8, "R13");
      // R8 no match over all entries, with R12 busy stimulus during the scan
      send(mk_hi(0, 0, 0, 2'd1, 8'h20), 0, 32'h0, 3'd7, 2'd1, 32'h0, 8, "R8");
      @(negedge clk);
      check(req_ready == 1'b0, "R12", "ready while scanning", 32'(req_ready), 32'd0);
      req_valid = 1'b1; req_hi = mk_hi(1, 0, 0, 2'd1, 8'h00); req_mid = 0; req_lo = 32'h77;
      @(negedge clk);
      req_valid = 1'b0;

      // R6 entry with n clear stops the scan at entry 2
      tbl_write(2, mk_hi(0, 0, 0, 2'd2, 8'h30), 32'h0004_0000);
      send(mk_hi(0, 0, 0, 2'd2, 8'h30), 0, 32'h0, 3'd5, 2'd2, 32'h0, 3, "R6");

      repeat (20) @(negedge clk);
      check(sb_q.size() == 0, "R12", "results outstanding", 32'(sb_q.size()), 32'd0);
      summary();
   end

endmodule